// File: doc/BRIEF.md
# Skip-Ordered-Set Elastic Buffer

This block carries a received symbol stream from the recovered receive clock into the local clock domain when the two clocks run at nearly, but not exactly, the same rate. One symbol arrives on every receive clock cycle. A symbol is a byte plus a control flag. The output side emits one symbol per local clock cycle once the buffer has filled.

The frequency mismatch is absorbed in one way only. The fill level is steered back toward the midpoint of a 16-entry store. When the transmitter sends a skip ordered set, one skip symbol of that set may be discarded on the write side or repeated on the read side. This is a control comma followed by several skip symbols. All other symbols pass through untouched and in order.

Status outputs in the local domain report each addition and each removal. Two sticky flags report that the buffer filled or emptied in spite of the correction.

Top module: `elastic_skip_buffer`

## Requirements
- R1: A skip symbol is a control symbol with byte 0x1C, and a comma is a control symbol with byte 0xBC. Only a skip symbol directly preceded by a comma or by another skip of the same set can be added or removed. A 0x1C byte without the control flag, and a lone skip with no comma before it, are never touched, and no adjustment pulse is raised for them.
- R2: Every symbol that is not a skip inside a set is delivered on `out_data_o`/`out_k_o` unchanged and in arrival order. The write and read pointers cross the clock domains Gray coded, and the fill level seen on either side never exceeds the depth.
- R3: When the write-side fill level is above the midpoint plus the synchronizer slack, one skip of the current set is discarded. The discarded skip is never the first skip of the set. At most one skip is discarded per set, and each removal gives a one-cycle pulse on `skip_removed_o`.
- R4: When the read-side fill level is below the midpoint minus the slack, one skip of the current set is emitted twice. At most one skip is repeated per set, and each repeat gives a one-cycle pulse on `skip_added_o`.
- R5: A set written with three skips leaves the buffer with two, three or four skips after its comma.
- R6: After reset, `out_valid_o` stays low until the read side sees the buffer at least half full. After an underflow, output again waits for half full.
- R7: A write that finds the buffer full is discarded and sets `overflow_o`. A read that finds the buffer empty once output has begun sets `underflow_o`. Both flags stay set until reset.
- R8: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Recovered receive clock |
| wrst_n_i | input | 1 | Synchronous active-low reset, receive domain |
| in_data_i | input | 8 | Received symbol byte |
| in_k_i | input | 1 | Received symbol control flag |
| lclk_i | input | 1 | Local clock |
| lrst_n_i | input | 1 | Synchronous active-low reset, local domain |
| out_data_o | output | 8 | Output symbol byte |
| out_k_o | output | 1 | Output symbol control flag |
| out_valid_o | output | 1 | Output symbol is valid |
| overflow_o | output | 1 | Sticky: buffer was full on a write |
| underflow_o | output | 1 | Sticky: buffer was empty on a read |
| skip_added_o | output | 1 | Pulse: one skip symbol repeated |
| skip_removed_o | output | 1 | Pulse: one skip symbol discarded |

## Verification
A skip repeat on the read side can happen in the same local cycle that a removal pulse, crossed over from the write side, lands. Both can also act on consecutive sets while the clock ratio changes.

The bench provokes this by switching the receive clock from 1% fast to 1% slow in mid-stream, while sets keep arriving every 40 symbols. A queue-based scoreboard judges the result. It requires every non-skip symbol in order, and each skip run after a comma to hold between two and four skips, whichever correction fired.

// File: rtl/eb_pkg.sv
// Shared constants and the stored entry type for the elastic buffer.
package eb_pkg;
    localparam logic [7:0] COMMA_BYTE = 8'hBC;
    localparam logic [7:0] SKIP_BYTE  = 8'h1C;

    // One stored symbol; in_set marks a skip that belongs to a skip ordered set.
    typedef struct packed {
        logic       in_set;
        logic       k;
        logic [7:0] data;
    } eb_entry_t;
endpackage

// File: rtl/eb_sync.sv
// Multi-flop synchronizer for a vector of quasi-static or Gray-coded bits.
// Assumes that at most one bit changes between consecutive source updates.
module eb_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First capture flop of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later flops settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= '0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eb_store.sv
// Dual-clock symbol store: registered write on the receive clock,
// combinational read addressed from the local clock domain.
// Assumes the pointer logic never reads an entry that is being written.
module eb_store #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  eb_pkg::eb_entry_t wentry,
    input  logic [AW-1:0]     raddr,
    output eb_pkg::eb_entry_t rentry
);
    eb_pkg::eb_entry_t mem [DEPTH];

    // Store one entry per enabled write cycle.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wentry;
    end

    assign rentry = mem[raddr];
endmodule

// File: rtl/eb_wr_ctl.sv
// Write-side control in the receive domain. It tracks skip ordered sets,
// discards one skip per set when the fill level is high, and blocks writes
// into a full store (sticky overflow). Assumes rptr_gray_s is already
// synchronized into this clock domain.
module eb_wr_ctl #(
    parameter int DEPTH = 16,
    parameter int SLACK = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int MID  = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_data,
    input  logic              in_k,
    input  logic [PW-1:0]     rptr_gray_s,
    output logic [PW-1:0]     wptr_gray,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output eb_pkg::eb_entry_t wentry,
    output logic              drop_tgl,
    output logic              ovf_sticky
);
    import eb_pkg::*;

    logic [PW-1:0] wptr_bin, wptr_nxt, rptr_bin_s, fill_w;
    logic          is_com, is_skp, skp_in_set;
    logic          set_q, prev_skp_q, dropped_q;
    logic          drop, full;

    // Convert the synchronized Gray read pointer to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) rptr_bin_s[i] = ^(rptr_gray_s >> i);
    end

    // Classify the incoming symbol and decide drop or write.
    always_comb begin
        is_com     = in_k && (in_data == COMMA_BYTE);
        is_skp     = in_k && (in_data == SKIP_BYTE);
        skp_in_set = is_skp && set_q;
        fill_w     = wptr_bin - rptr_bin_s;
        full       = fill_w >= PW'(DEPTH);
        drop       = skp_in_set && prev_skp_q && !dropped_q && (fill_w > PW'(MID + SLACK));
        we         = !drop && !full;
        wptr_nxt   = wptr_bin + 1'b1;
    end

    assign waddr  = wptr_bin[AW-1:0];
    assign wentry = '{in_set: skp_in_set, k: in_k, data: in_data};

    // Set tracking, pointer advance, drop notification and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q      <= 1'b0;
            prev_skp_q <= 1'b0;
            dropped_q  <= 1'b0;
            wptr_bin   <= '0;
            wptr_gray  <= '0;
            drop_tgl   <= 1'b0;
            ovf_sticky <= 1'b0;
        end else begin
            set_q      <= is_com || skp_in_set;
            prev_skp_q <= skp_in_set;
            dropped_q  <= skp_in_set ? (dropped_q || drop) : 1'b0;
            if (drop) drop_tgl <= ~drop_tgl;
            if (!drop && full) ovf_sticky <= 1'b1;
            if (we) begin
                wptr_bin  <= wptr_nxt;
                wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
            end
        end
    end

    // R3: a removal is never followed by a second removal on the next symbol.
    p_one_drop_per_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !drop);
    // R2: the write-side fill level never exceeds the depth.
    p_wr_fill_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_w <= PW'(DEPTH));
endmodule

// File: rtl/eb_rd_ctl.sv
// Read-side control in the local domain. It holds output until half full,
// repeats one skip per set when the fill level is low, and flags underflow.
// Assumes wptr_gray_s is already synchronized into this clock domain.
module eb_rd_ctl #(
    parameter int DEPTH = 16,
    parameter int SLACK = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int MID  = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     wptr_gray_s,
    input  eb_pkg::eb_entry_t rentry,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rptr_gray,
    output logic [7:0]        out_data,
    output logic              out_k,
    output logic              out_valid,
    output logic              skip_add,
    output logic              unf_sticky
);
    logic [PW-1:0] rptr_bin, rptr_nxt, wptr_bin_s, fill_r;
    logic          primed_q, inserted_q, insert;

    // Convert the synchronized Gray write pointer to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) wptr_bin_s[i] = ^(wptr_gray_s >> i);
    end

    // Fill level and the repeat decision for the entry at the read pointer.
    always_comb begin
        fill_r   = wptr_bin_s - rptr_bin;
        insert   = rentry.in_set && !inserted_q && (fill_r < PW'(MID - SLACK));
        rptr_nxt = rptr_bin + 1'b1;
    end

    assign raddr = rptr_bin[AW-1:0];

    // Priming, output, skip repeat and underflow handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_bin   <= '0;
            rptr_gray  <= '0;
            primed_q   <= 1'b0;
            inserted_q <= 1'b0;
            out_data   <= '0;
            out_k      <= 1'b0;
            out_valid  <= 1'b0;
            skip_add   <= 1'b0;
            unf_sticky <= 1'b0;
        end else begin
            skip_add <= 1'b0;
            if (!primed_q) begin
                out_valid <= 1'b0;
                if (fill_r >= PW'(MID)) primed_q <= 1'b1;
            end else if (fill_r == '0) begin
                out_valid  <= 1'b0;
                unf_sticky <= 1'b1;
                primed_q   <= 1'b0;
                inserted_q <= 1'b0;
            end else begin
                out_valid <= 1'b1;
                out_data  <= rentry.data;
                out_k     <= rentry.k;
                if (insert) begin
                    skip_add   <= 1'b1;
                    inserted_q <= 1'b1;
                end else begin
                    rptr_bin   <= rptr_nxt;
                    rptr_gray  <= rptr_nxt ^ (rptr_nxt >> 1);
                    inserted_q <= rentry.in_set ? inserted_q : 1'b0;
                end
            end
        end
    end

    // R4: a repeat is never followed by another repeat on the next cycle.
    p_one_insert_per_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        skip_add |=> !skip_add);
    // R6: no output while the buffer is not primed.
    p_hold_until_primed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_q |=> !out_valid);
    // R2: the read-side fill level never exceeds the depth.
    p_rd_fill_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_r <= PW'(DEPTH));
endmodule

// File: rtl/elastic_skip_buffer.sv
// Top of the skip-based elastic buffer. It joins the store, both side
// controllers and the pointer and status synchronizers. Assumes both clocks
// are close in frequency and that skip sets arrive often enough for one
// correction per set to cover the drift.
module elastic_skip_buffer #(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       wclk_i,
    input  logic       wrst_n_i,
    input  logic [7:0] in_data_i,
    input  logic       in_k_i,
    input  logic       lclk_i,
    input  logic       lrst_n_i,
    output logic [7:0] out_data_o,
    output logic       out_k_o,
    output logic       out_valid_o,
    output logic       overflow_o,
    output logic       underflow_o,
    output logic       skip_added_o,
    output logic       skip_removed_o
);
    localparam int AW    = $clog2(DEPTH);
    localparam int PW    = AW + 1;
    localparam int SLACK = SYNC_STAGES + 2;

    logic [PW-1:0]     wptr_gray, wptr_gray_s, rptr_gray, rptr_gray_s;
    logic              we, drop_tgl, ovf_w;
    logic [AW-1:0]     waddr, raddr;
    eb_pkg::eb_entry_t wentry, rentry;
    logic [1:0]        flags_s;
    logic              tgl_q;

    eb_store #(.DEPTH(DEPTH)) u_store (
        .wclk(wclk_i), .we(we), .waddr(waddr), .wentry(wentry),
        .raddr(raddr), .rentry(rentry)
    );

    eb_wr_ctl #(.DEPTH(DEPTH), .SLACK(SLACK)) u_wr (
        .clk(wclk_i), .rst_n(wrst_n_i), .in_data(in_data_i), .in_k(in_k_i),
        .rptr_gray_s(rptr_gray_s), .wptr_gray(wptr_gray), .we(we),
        .waddr(waddr), .wentry(wentry), .drop_tgl(drop_tgl), .ovf_sticky(ovf_w)
    );

    eb_rd_ctl #(.DEPTH(DEPTH), .SLACK(SLACK)) u_rd (
        .clk(lclk_i), .rst_n(lrst_n_i), .wptr_gray_s(wptr_gray_s),
        .rentry(rentry), .raddr(raddr), .rptr_gray(rptr_gray),
        .out_data(out_data_o), .out_k(out_k_o), .out_valid(out_valid_o),
        .skip_add(skip_added_o), .unf_sticky(underflow_o)
    );

    eb_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync_rptr (
        .clk(wclk_i), .rst_n(wrst_n_i), .d(rptr_gray), .q(rptr_gray_s)
    );

    eb_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync_wptr (
        .clk(lclk_i), .rst_n(lrst_n_i), .d(wptr_gray), .q(wptr_gray_s)
    );

    eb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync_flags (
        .clk(lclk_i), .rst_n(lrst_n_i), .d({ovf_w, drop_tgl}), .q(flags_s)
    );

    assign overflow_o = flags_s[1];

    // Turn each crossed toggle of the removal indicator into a pulse.
    always_ff @(posedge lclk_i) begin
        if (!lrst_n_i) begin
            tgl_q          <= 1'b0;
            skip_removed_o <= 1'b0;
        end else begin
            tgl_q          <= flags_s[0];
            skip_removed_o <= flags_s[0] ^ tgl_q;
        end
    end

    // R7: overflow stays set until reset.
    p_sticky_overflow_r7: assert property (@(posedge lclk_i)
        disable iff (!lrst_n_i || !wrst_n_i) overflow_o |=> overflow_o);
    // R7: underflow stays set until reset.
    p_sticky_underflow_r7: assert property (@(posedge lclk_i)
        disable iff (!lrst_n_i || !wrst_n_i) underflow_o |=> underflow_o);
endmodule

// File: tb/elastic_skip_buffer_tb.sv
`timescale 1ns/1ps
module elastic_skip_buffer_tb;
    logic       wclk = 1'b0, lclk = 1'b0;
    logic       wrst_n = 1'b0, lrst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_k = 1'b0;
    logic [7:0] out_data_o;
    logic       out_k_o, out_valid_o, overflow_o, underflow_o;
    logic       skip_added_o, skip_removed_o;
    realtime    whalf = 10.0;

    int         checks = 0, errors = 0;
    int         run = 0, add_cnt = 0, del_cnt = 0, pop_cnt = 0, sym_idx = 0;
    bit         sb_en = 1'b0;
    logic [8:0] exp_q [$];

    elastic_skip_buffer u_dut (
        .wclk_i(wclk), .wrst_n_i(wrst_n), .in_data_i(in_data), .in_k_i(in_k),
        .lclk_i(lclk), .lrst_n_i(lrst_n), .out_data_o(out_data_o),
        .out_k_o(out_k_o), .out_valid_o(out_valid_o), .overflow_o(overflow_o),
        .underflow_o(underflow_o), .skip_added_o(skip_added_o),
        .skip_removed_o(skip_removed_o)
    );

    always #10 lclk = ~lclk;
    always #(whalf) wclk = ~wclk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: present a symbol, queue it if the scoreboard expects it.
    task automatic send(input logic k, input logic [7:0] d, input bit push);
        in_k    = k;
        in_data = d;
        if (push && sb_en) exp_q.push_back({k, d});
        @(negedge wclk);
    endtask

    task automatic send_set();
        send(1'b1, 8'hBC, 1'b1);
        repeat (3) send(1'b1, 8'h1C, 1'b0);
    endtask

    task automatic stream(input int n, input bit with_sets, input bit lone_skp);
        for (int i = 0; i < n; i++) begin
            sym_idx++;
            if (with_sets && (i % 40 == 39)) send_set();
            else if (i % 17 == 5) send(1'b0, 8'h1C, 1'b1);
            else if (i % 23 == 7) send(1'b1, 8'hFB, 1'b1);
            else if (lone_skp && (i % 29 == 3)) send(1'b1, 8'h1C, 1'b0);
            else send(1'b0, 8'(sym_idx * 37 + 11), 1'b1);
        end
    endtask

    task automatic do_reset(input bit en);
        sb_en  = 1'b0;
        wrst_n = 1'b0;
        lrst_n = 1'b0;
        repeat (5) @(negedge lclk);
        // R8: all outputs are zero while reset is held
        chk({out_valid_o, out_k_o, out_data_o, overflow_o, underflow_o,
             skip_added_o, skip_removed_o} == '0, "R8", out_valid_o, 0);
        exp_q.delete();
        run = 0; add_cnt = 0; del_cnt = 0;
        @(negedge lclk);
        lrst_n = 1'b1;
        @(negedge wclk);
        wrst_n = 1'b1;
        sb_en  = en;
    endtask

    // Monitor: count pulses and compare the output against the scoreboard.
    always @(negedge lclk) begin
        if (lrst_n) begin
            if (skip_added_o) add_cnt++;
            if (skip_removed_o) del_cnt++;
            if (sb_en && out_valid_o) begin
                if (out_k_o && out_data_o == 8'h1C) run++;
                else begin
                    if (run > 0) chk(run >= 2 && run <= 4, "R5", run, 3);
                    run = 0;
                    if (exp_q.size() == 0) chk(1'b0, "R2", {out_k_o, out_data_o}, -1);
                    else begin
                        logic [8:0] e;
                        e = exp_q.pop_front();
                        pop_cnt++;
                        chk({out_k_o, out_data_o} == e, "R2", {out_k_o, out_data_o}, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge lclk);
        checks++; errors++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        whalf = 10.0;
        do_reset(1'b1);
        fork
            stream(1500, 1'b1, 1'b0);
            begin
                for (int c = 0; c < 5; c++) begin
                    @(negedge lclk);
                    chk(!out_valid_o, "R6", out_valid_o, 0); // held until half full
                end
            end
        join
        // Receive clock 1% fast: removals must occur (R3).
        whalf = 9.9; del_cnt = 0;
        stream(3000, 1'b1, 1'b0);
        chk(del_cnt > 0, "R3", del_cnt, 1);
        chk(!overflow_o && !underflow_o, "R7", {overflow_o, underflow_o}, 0);
        // Receive clock 1% slow: repeats must occur (R4).
        whalf = 10.1; add_cnt = 0;
        stream(3000, 1'b1, 1'b0);
        chk(add_cnt > 0, "R4", add_cnt, 1);
        chk(!overflow_o && !underflow_o, "R7", {overflow_o, underflow_o}, 0);
        chk(exp_q.size() <= 24, "R2", exp_q.size(), 24);
        chk(pop_cnt > 6000, "R2", pop_cnt, 6000);
        sb_en = 1'b0;

        // Overflow without skip sets; lone skips must stay untouched (R1).
        whalf = 9.5;
        do_reset(1'b0);
        stream(800, 1'b0, 1'b1);
        repeat (10) @(negedge lclk);
        chk(overflow_o == 1'b1, "R7", overflow_o, 1);
        chk(underflow_o == 1'b0, "R7", underflow_o, 0);
        chk(del_cnt == 0 && add_cnt == 0, "R1", del_cnt + add_cnt, 0);

        // Underflow without skip sets (R7, R1).
        whalf = 10.5;
        do_reset(1'b0);
        stream(800, 1'b0, 1'b1);
        repeat (10) @(negedge lclk);
        chk(underflow_o == 1'b1, "R7", underflow_o, 1);
        chk(overflow_o == 1'b0, "R7", overflow_o, 0);
        chk(del_cnt == 0 && add_cnt == 0, "R1", del_cnt + add_cnt, 0);

        finish_run();
    end
endmodule